// File: doc/BRIEF.md
# Power Mode Supervisor State Machine

This block is the central mode controller of a companion chip that supplies a host processor and its bus transceivers. It holds the chip in one of six operating modes (init, normal, stop, sleep, restart and fail-safe). It decides, on every clock, whether a host command, a wake event, an I/O-supply voltage fault, a thermal shutdown or an escalation request from a neighbouring supervisor changes that mode. From the mode it drives the host reset line, the enable of the main supply, the fail output, a sticky command-fail flag and a wake interrupt.

Time is measured in ticks of a one-millisecond strobe. The restart delay and the two minimum fail-safe dwell times are parameters counted in those ticks. Illegal or unsafe requests are not simply dropped. A direct stop-to-sleep request is turned into a pass through restart and sets the command-fail flag. A sleep request that could never be woken from also passes through restart, as does a sleep request made while a wake is still pending. A run of I/O-supply undervoltage events that would otherwise loop through restart without end is escalated to fail-safe.

Mode codes on `mode_o`: 0 init, 1 normal, 2 stop, 3 sleep, 4 restart, 5 fail-safe. Host commands are given by `cmd_kind`: 0 mode change (target in `cmd_mode` using the mode codes), 1 soft reset, 2 watchdog refresh, 3 clear flags, 4 to 7 configuration writes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After synchronous reset the mode is init (code 0), `rst_n_o` is high, `main_en` is high, and `fail_out`, `cmd_fail` and `wake_irq` are low.
- R2: In init, any valid command of any kind moves the mode to normal on the next clock. Wake events in init are discarded and change neither the mode nor `wake_irq`.
- R3: In stop, a mode change with target sleep (code 3) sets `cmd_fail` and moves to restart. Restart then exits to normal as described in R5.
- R4: In normal, a mode change to sleep while `wake_pend` is high or `wake_en` is low goes to restart. Otherwise it goes to sleep, and `rst_n_o` and `main_en` go low on the same clock as the mode change.
- R5: Restart holds `rst_n_o` low and exits to normal on the clock after the tick counter has reached RST_DLY_TICKS, provided `vio_uv` is low. `rst_n_o` rises on that same clock.
- R6: A rising edge of `vio_uv` in init, normal or stop goes to restart. The UV_LIMIT-th such edge with no watchdog refresh (kind 2) in between goes to fail-safe instead.
- R7: Fail-safe lasts at least FS_TSD_TICKS ticks when it was entered through `tsd`, and at least FS_OTHER_TICKS ticks for any other cause. A wake arriving during that dwell is stored, and on the clock after the dwell ends the mode goes to restart.
- R8: In stop, command kinds 3 to 7 and mode-change targets other than normal, stop or sleep leave the mode unchanged and set `cmd_fail`. Kinds 1 and 2 are accepted. In normal, a mode-change target of init, restart or fail-safe (codes 0, 4, 5 and up) also sets `cmd_fail` and leaves the mode unchanged.
- R9: In fail-safe `main_en` is low and `fail_out` is high. `fail_out` stays high through restart, fail-safe and normal until a clear-flags command (kind 3) in normal, which also clears `cmd_fail`.
- R10: In normal and stop, a wake event gives a one-cycle pulse on `wake_irq` and does not change the mode.
- R11: In sleep, a wake event goes to restart. An `esc_rst` request in init, normal or stop goes to restart and sets `fail_out`. `esc_fs` or `tsd` goes to fail-safe from any other mode.
- R12: A soft reset command (kind 1) in normal or stop moves the mode to init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| cmd_valid | input | 1 | Host command strobe |
| cmd_kind | input | 3 | Command kind |
| cmd_mode | input | 3 | Target mode of a mode-change command |
| wake_evt | input | 1 | Wake event pulse |
| wake_en | input | 1 | At least one wake source is enabled |
| wake_pend | input | 1 | A wake flag is still set |
| vio_uv | input | 1 | I/O-supply undervoltage |
| tsd | input | 1 | Thermal shutdown |
| esc_rst | input | 1 | Escalation request to restart |
| esc_fs | input | 1 | Escalation request to fail-safe |
| rst_n_o | output | 1 | Host reset, active low |
| main_en | output | 1 | Main supply enable |
| fail_out | output | 1 | Fail output, active high |
| cmd_fail | output | 1 | Sticky command-fail flag |
| wake_irq | output | 1 | Wake interrupt pulse |
| mode_o | output | 3 | Current mode code |

## Verification
Several properties are checked on every cycle. Sleep and fail-safe always hold reset low, fail-safe never has the main supply on, and stop never leads straight to sleep. Restart only exits to normal or fail-safe, a rising reset line coincides with normal, and the fail output never drops without a clear command. Other behaviour can only be shown by the bench's scenarios. This covers the exact tick counts of the restart delay and of the two fail-safe dwells, the storing of a wake across the dwell, and the count of undervoltage events before escalation. It also covers the sweep of rejected command kinds in stop, which shows each one setting the flag while the mode stays put.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    M_INIT    = 3'd0,
    M_NORMAL  = 3'd1,
    M_STOP    = 3'd2,
    M_SLEEP   = 3'd3,
    M_RESTART = 3'd4,
    M_FSAFE   = 3'd5
  } pm_mode_e;

  localparam logic [2:0] K_MODE  = 3'd0;
  localparam logic [2:0] K_SOFT  = 3'd1;
  localparam logic [2:0] K_WDREF = 3'd2;
  localparam logic [2:0] K_CLR   = 3'd3;
endpackage

// File: rtl/pm_dwell_timer.sv
module pm_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (tick && cnt_q != limit)
      cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == limit);
endmodule

// File: rtl/pm_uv_escalator.sv
module pm_uv_escalator #(
  parameter int UV_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic uv,
  input  logic count_en,
  input  logic clr,
  output logic uv_event,
  output logic uv_escalate
);
  localparam int UW = $clog2(UV_LIMIT + 1);
  localparam logic [UW-1:0] LAST = UW'(UV_LIMIT - 1);

  logic          uv_q;
  logic [UW-1:0] cnt_q;

  assign uv_event    = count_en && uv && !uv_q;
  assign uv_escalate = uv_event && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      uv_q <= uv;
      if (clr || uv_escalate)
        cnt_q <= '0;
      else if (uv_event)
        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int RST_DLY_TICKS  = 10,
  parameter int FS_TSD_TICKS   = 1000,
  parameter int FS_OTHER_TICKS = 100,
  parameter int UV_LIMIT       = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_ms,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_kind,
  input  logic [2:0] cmd_mode,
  input  logic       wake_evt,
  input  logic       wake_en,
  input  logic       wake_pend,
  input  logic       vio_uv,
  input  logic       tsd,
  input  logic       esc_rst,
  input  logic       esc_fs,
  output logic       rst_n_o,
  output logic       main_en,
  output logic       fail_out,
  output logic       cmd_fail,
  output logic       wake_irq,
  output logic [2:0] mode_o
);
  localparam int MAXT = (FS_TSD_TICKS > FS_OTHER_TICKS) ?
                        ((FS_TSD_TICKS > RST_DLY_TICKS) ? FS_TSD_TICKS : RST_DLY_TICKS) :
                        ((FS_OTHER_TICKS > RST_DLY_TICKS) ? FS_OTHER_TICKS : RST_DLY_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] L_RST = CW'(RST_DLY_TICKS);
  localparam logic [CW-1:0] L_TSD = CW'(FS_TSD_TICKS);
  localparam logic [CW-1:0] L_OTH = CW'(FS_OTHER_TICKS);

  pm_mode_e st_q, st_d;
  logic fs_tsd_q, fs_tsd_d;
  logic wstore_q, wstore_d;
  logic fail_q, cmdf_q, irq_q, rstn_q, men_q;
  logic set_cmdf, set_fail, clr_flags, irq_d;
  logic awake, uv_clr, uv_evt, uv_esc, rdly_done, fs_done;

  assign awake  = (st_q == M_INIT) || (st_q == M_NORMAL) || (st_q == M_STOP);
  assign uv_clr = awake && cmd_valid && (cmd_kind == K_WDREF);

  pm_uv_escalator #(.UV_LIMIT(UV_LIMIT)) u_uv (
    .clk(clk), .rst(rst), .uv(vio_uv), .count_en(awake), .clr(uv_clr),
    .uv_event(uv_evt), .uv_escalate(uv_esc)
  );

  pm_dwell_timer #(.CW(CW)) u_rdly (
    .clk(clk), .rst(rst), .run(st_q == M_RESTART), .tick(tick_ms),
    .limit(L_RST), .done(rdly_done)
  );

  pm_dwell_timer #(.CW(CW)) u_fsdw (
    .clk(clk), .rst(rst), .run(st_q == M_FSAFE), .tick(tick_ms),
    .limit(fs_tsd_q ? L_TSD : L_OTH), .done(fs_done)
  );

  always_comb begin
    st_d      = st_q;
    fs_tsd_d  = fs_tsd_q;
    wstore_d  = wstore_q;
    set_cmdf  = 1'b0;
    set_fail  = 1'b0;
    clr_flags = 1'b0;
    irq_d     = wake_evt && ((st_q == M_NORMAL) || (st_q == M_STOP));
    if (tsd && st_q != M_FSAFE) begin
      st_d = M_FSAFE; fs_tsd_d = 1'b1;
    end else if (esc_fs && st_q != M_FSAFE) begin
      st_d = M_FSAFE; fs_tsd_d = 1'b0;
    end else if (uv_esc) begin
      st_d = M_FSAFE; fs_tsd_d = 1'b0;
    end else if (uv_evt) begin
      st_d = M_RESTART;
    end else if (esc_rst && awake) begin
      st_d = M_RESTART; set_fail = 1'b1;
    end else begin
      unique case (st_q)
        M_INIT: if (cmd_valid) st_d = M_NORMAL;
        M_NORMAL: if (cmd_valid) begin
          case (cmd_kind)
            K_MODE: begin
              if (cmd_mode == M_STOP) st_d = M_STOP;
              else if (cmd_mode == M_SLEEP)
                st_d = (wake_pend || !wake_en) ? M_RESTART : M_SLEEP;
              else if (cmd_mode != M_NORMAL) set_cmdf = 1'b1;
            end
            K_SOFT:  st_d = M_INIT;
            K_CLR:   clr_flags = 1'b1;
            default: ;
          endcase
        end
        M_STOP: if (cmd_valid) begin
          case (cmd_kind)
            K_MODE: begin
              if (cmd_mode == M_NORMAL) st_d = M_NORMAL;
              else if (cmd_mode == M_SLEEP) begin
                st_d = M_RESTART; set_cmdf = 1'b1;
              end else if (cmd_mode != M_STOP) set_cmdf = 1'b1;
            end
            K_SOFT:  st_d = M_INIT;
            K_WDREF: ;
            default: set_cmdf = 1'b1;
          endcase
        end
        M_SLEEP: if (wake_evt) st_d = M_RESTART;
        M_RESTART: if (rdly_done && !vio_uv) st_d = M_NORMAL;
        M_FSAFE: begin
          if (wake_evt) wstore_d = 1'b1;
          if (fs_done && (wstore_q || wake_evt)) st_d = M_RESTART;
        end
        default: st_d = M_INIT;
      endcase
    end
    if (st_d != M_FSAFE) wstore_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= M_INIT;
      fs_tsd_q <= 1'b0;
      wstore_q <= 1'b0;
      fail_q   <= 1'b0;
      cmdf_q   <= 1'b0;
      irq_q    <= 1'b0;
      rstn_q   <= 1'b1;
      men_q    <= 1'b1;
    end else begin
      st_q     <= st_d;
      fs_tsd_q <= fs_tsd_d;
      wstore_q <= wstore_d;
      irq_q    <= irq_d;
      rstn_q   <= !((st_d == M_RESTART) || (st_d == M_SLEEP) || (st_d == M_FSAFE));
      men_q    <= !((st_d == M_SLEEP) || (st_d == M_FSAFE));
      if (clr_flags) begin
        fail_q <= 1'b0;
        cmdf_q <= 1'b0;
      end else begin
        if (set_fail || st_d == M_FSAFE) fail_q <= 1'b1;
        if (set_cmdf) cmdf_q <= 1'b1;
      end
    end
  end

  assign mode_o   = st_q;
  assign rst_n_o  = rstn_q;
  assign main_en  = men_q;
  assign fail_out = fail_q;
  assign cmd_fail = cmdf_q;
  assign wake_irq = irq_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       wake_evt,
  input logic       vio_uv,
  input logic       tsd,
  input logic       esc_rst,
  input logic       esc_fs,
  input logic       rst_n_o,
  input logic       main_en,
  input logic       fail_out,
  input logic [2:0] mode_o
);
  AST_SLEEP_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3) |-> !rst_n_o); // R4
  AST_FSAFE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd5) |-> (!main_en && fail_out && !rst_n_o)); // R9
  AST_STOP_NOT_TO_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |=> (mode_o != 3'd3)); // R3
  AST_RESTART_EXITS: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd1 || mode_o == 3'd5)); // R5
  AST_RESET_RISE_NORMAL: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> (mode_o == 3'd1)); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fail_out && !(cmd_valid && cmd_kind == 3'd3)) |=> fail_out); // R9
  AST_INIT_WAKE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0 && wake_evt && !cmd_valid && !vio_uv && !tsd && !esc_rst && !esc_fs)
    |=> (mode_o == 3'd0)); // R2
  AST_NORMAL_WAKE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1 && wake_evt && !cmd_valid && !vio_uv && !tsd && !esc_rst && !esc_fs)
    |=> (mode_o == 3'd1)); // R10
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .wake_evt(wake_evt), .vio_uv(vio_uv), .tsd(tsd), .esc_rst(esc_rst),
  .esc_fs(esc_fs), .rst_n_o(rst_n_o), .main_en(main_en),
  .fail_out(fail_out), .mode_o(mode_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int RD = 3, FT = 8, FO = 4, UL = 4;

  logic clk = 1'b0, rst = 1'b1, tick_ms = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_kind = '0, cmd_mode = '0;
  logic wake_evt = 1'b0, wake_en = 1'b1, wake_pend = 1'b0;
  logic vio_uv = 1'b0, tsd = 1'b0, esc_rst = 1'b0, esc_fs = 1'b0;
  logic rst_n_o, main_en, fail_out, cmd_fail, wake_irq;
  logic [2:0] mode_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.RST_DLY_TICKS(RD), .FS_TSD_TICKS(FT), .FS_OTHER_TICKS(FO), .UV_LIMIT(UL)) u0 (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_mode(cmd_mode), .wake_evt(wake_evt), .wake_en(wake_en), .wake_pend(wake_pend),
    .vio_uv(vio_uv), .tsd(tsd), .esc_rst(esc_rst), .esc_fs(esc_fs), .rst_n_o(rst_n_o),
    .main_en(main_en), .fail_out(fail_out), .cmd_fail(cmd_fail), .wake_irq(wake_irq),
    .mode_o(mode_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_ms = 1'b1; @(negedge clk);
    end
    tick_ms = 1'b0;
  endtask

  task automatic send(input logic [2:0] k, input logic [2:0] m);
    cmd_valid = 1'b1; cmd_kind = k; cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wake;
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic recover(input string req);
    ticks(RD);
    chk({req, " restart held until delay"}, mode_o, 4);
    chk({req, " reset low in restart"}, rst_n_o, 0);
    step(1);
    chk({req, " restart exit to normal"}, mode_o, 1);
    chk({req, " reset released"}, rst_n_o, 1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    chk("R1 mode", mode_o, 0);
    chk("R1 rst_n_o", rst_n_o, 1);
    chk("R1 main_en", main_en, 1);
    chk("R1 fail_out", fail_out, 0);
    chk("R1 cmd_fail", cmd_fail, 0);
    chk("R1 wake_irq", wake_irq, 0);

    wake();
    chk("R2 wake ignored in init", mode_o, 0);
    chk("R2 no irq in init", wake_irq, 0);
    send(3'd6, 3'd0);
    chk("R2 config write leaves init", mode_o, 1);

    wake();
    chk("R10 irq in normal", wake_irq, 1);
    chk("R10 mode kept normal", mode_o, 1);
    step(1);
    chk("R10 irq one cycle", wake_irq, 0);

    wake_pend = 1'b1;
    send(3'd0, 3'd3);
    chk("R4 pending wake to restart", mode_o, 4);
    wake_pend = 1'b0;
    ticks(RD - 1); step(1);
    chk("R5 not before delay", mode_o, 4);
    ticks(1); step(1);
    chk("R5 exit after delay", mode_o, 1);
    chk("R5 reset released", rst_n_o, 1);

    wake_en = 1'b0;
    send(3'd0, 3'd3);
    chk("R4 no wake source to restart", mode_o, 4);
    wake_en = 1'b1;
    vio_uv = 1'b1;
    ticks(RD); step(2);
    chk("R5 held while undervoltage", mode_o, 4);
    vio_uv = 1'b0;
    step(1);
    chk("R5 exit after undervoltage clears", mode_o, 1);

    send(3'd0, 3'd3);
    chk("R4 sleep accepted", mode_o, 3);
    chk("R4 reset with sleep", rst_n_o, 0);
    chk("R4 supply off in sleep", main_en, 0);
    wake();
    chk("R11 sleep wake to restart", mode_o, 4);
    recover("R11");

    send(3'd0, 3'd2);
    chk("R8 enter stop", mode_o, 2);
    for (int k = 3; k < 8; k++) begin
      send(3'(k), 3'd0);
      chk($sformatf("R8 stop kind %0d mode", k), mode_o, 2);
      chk($sformatf("R8 stop kind %0d cmd_fail", k), cmd_fail, 1);
    end
    send(3'd2, 3'd0);
    chk("R8 refresh accepted in stop", mode_o, 2);
    wake();
    chk("R10 irq in stop", wake_irq, 1);
    chk("R10 stop kept", mode_o, 2);
    send(3'd0, 3'd3);
    chk("R3 stop to sleep goes restart", mode_o, 4);
    chk("R3 cmd_fail", cmd_fail, 1);
    recover("R3");
    send(3'd3, 3'd0);
    chk("R9 clear flags cmd_fail", cmd_fail, 0);

    send(3'd0, 3'd5);
    chk("R8 illegal target in normal flags", cmd_fail, 1);
    chk("R8 illegal target mode kept", mode_o, 1);
    send(3'd3, 3'd0);

    send(3'd1, 3'd0);
    chk("R12 soft reset to init", mode_o, 0);
    send(3'd2, 3'd0);
    chk("R2 refresh leaves init", mode_o, 1);

    for (int i = 1; i <= UL; i++) begin
      vio_uv = 1'b1; step(1); vio_uv = 1'b0;
      if (i < UL) begin
        chk($sformatf("R6 uv event %0d to restart", i), mode_o, 4);
        recover("R6");
      end else begin
        chk("R6 last uv event to fail-safe", mode_o, 5);
      end
    end
    chk("R9 supply off in fail-safe", main_en, 0);
    chk("R9 fail output on", fail_out, 1);
    wake();
    ticks(FO); step(0);
    chk("R7 dwell not yet over", mode_o, 5);
    step(1);
    chk("R7 stored wake to restart", mode_o, 4);
    chk("R9 fail kept in restart", fail_out, 1);
    recover("R7");
    chk("R9 fail kept in normal", fail_out, 1);
    send(3'd3, 3'd0);
    chk("R9 cleared by command", fail_out, 0);

    tsd = 1'b1; step(1); tsd = 1'b0;
    chk("R11 thermal to fail-safe", mode_o, 5);
    wake();
    ticks(FO); step(1);
    chk("R7 thermal dwell longer", mode_o, 5);
    ticks(FT - FO - 1); step(1);
    chk("R7 thermal dwell one short", mode_o, 5);
    ticks(1); step(1);
    chk("R7 thermal stored wake to restart", mode_o, 4);
    recover("R7");
    send(3'd3, 3'd0);

    esc_rst = 1'b1; step(1); esc_rst = 1'b0;
    chk("R11 escalation to restart", mode_o, 4);
    chk("R11 escalation sets fail", fail_out, 1);
    recover("R11");
    esc_fs = 1'b1; step(1); esc_fs = 1'b0;
    chk("R11 escalation to fail-safe", mode_o, 5);
    ticks(FO); step(3);
    chk("R7 no wake stays fail-safe", mode_o, 5);
    wake();
    chk("R7 wake after dwell to restart", mode_o, 4);

    finish_run();
  end
endmodule